// File: doc/BRIEF.md
# Port Inrush and Cool-Down Sequencer

This block runs one power-sourcing port through its power-up sequence. A power-on request opens a start window whose length is picked by a 2-bit select. The port is enabled for the whole window. When the window closes, the block looks at the inrush-limiting flag. If the flag is clear, the port is declared good. If the flag is still set, the port is shut off and a start-fault event is raised.

An overload or foldback-limit turn-off from the fault timers also shuts a good port off. Every shut-off leads into a blocking cool-down. During cool-down, requests do nothing and the port stays unpowered. The cool-down length is a base interval scaled by 1, 2, 4 or 8. When cool-down ends, the port is idle again. In semi-automatic or automatic mode, with both detect and class enabled, the block then issues a one-cycle request to restart detection.

All timing advances only on a millisecond tick input. Start windows are counted in ticks. The cool-down base is a parameter, also counted in ticks.

Top module: `port_start_seq`

## Requirements
- R1: After reset, pwr_en, pwr_good, start_done, start_fault and det_restart are all 0, and the port is idle.
- R2: An accepted request enables the port (pwr_en=1, pwr_good=0) for a start window of exactly 60, 30, 120 or 60 tick pulses for start_sel 00, 01, 10 or 11. Cycles without a tick do not shorten the window.
- R3: If inrush_lim is 0 on the final tick of the window, start_done pulses for one cycle. In that same cycle pwr_good and pwr_en are 1, and both stay 1.
- R4: If inrush_lim is 1 on the final tick of the window, start_fault pulses for one cycle. In that same cycle pwr_en and pwr_good are 0, and cool-down begins.
- R5: While the port is good, ovld_off=1 or flim_off=1 clears pwr_en and pwr_good on the next cycle and begins cool-down.
- R6: Cool-down lasts COOL_BASE_TICKS << cool_sel tick pulses. During cool-down pwr_en stays 0 and pwr_req is ignored. Afterwards the port is idle and remains unpowered without a new request.
- R7: At the end of cool-down, det_restart pulses for one cycle, in the first idle cycle, only if mode is 10 (semi-auto) or 11 (auto) and det_en=1 and cls_en=1. It never pulses in mode 00 (off) or 01 (manual).
- R8: pwr_req is ignored outside the idle state: it neither restarts a running window nor produces start_done on a good port. It is also ignored in mode 00 (off).
- R9: ovld_off and flim_off are ignored during the start window. The window runs to its full length.
- R10: pwr_good implies pwr_en, and at most one of start_done, start_fault and det_restart is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle millisecond tick |
| pwr_req | input | 1 | Power-on request |
| inrush_lim | input | 1 | Port current held at the inrush limit |
| ovld_off | input | 1 | Overload timer turn-off request |
| flim_off | input | 1 | Foldback-limit timer turn-off request |
| mode | input | 2 | 00 off, 01 manual, 10 semi-auto, 11 auto |
| det_en | input | 1 | Detection enable |
| cls_en | input | 1 | Classification enable |
| start_sel | input | 2 | Start-window select |
| cool_sel | input | 2 | Cool-down multiplier select (1x/2x/4x/8x) |
| pwr_good | output | 1 | Port powered past its start window |
| pwr_en | output | 1 | Port switch enable |
| start_done | output | 1 | One-cycle strobe: start window passed |
| start_fault | output | 1 | One-cycle strobe: start window failed |
| det_restart | output | 1 | One-cycle strobe: restart detection |

## Verification
The bench sweeps every combination of mode, start select and cool-down select, with the enable bits varied alongside them. This separates the four window lengths, the four cool-down multipliers and the gating of the restart by mode and enables.

The inrush flag alternates across the sweep, so both window outcomes are exercised, along with entry to cool-down from a start fault, an overload and a foldback turn-off. Stray requests and fault pulses are injected inside the window and on a good port. These show that the window is neither restarted nor cut short. A run with the tick held off shows that only ticks advance the window.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_INRUSH  = 2'd1,
    ST_POWERED = 2'd2,
    ST_COOL    = 2'd3
  } pss_state_e;

  localparam logic [1:0] MD_OFF    = 2'b00;
  localparam logic [1:0] MD_MANUAL = 2'b01;
  localparam logic [1:0] MD_SEMI   = 2'b10;
  localparam logic [1:0] MD_AUTO   = 2'b11;

  localparam int unsigned START_MS_SHORT   = 30;
  localparam int unsigned START_MS_NOMINAL = 60;
  localparam int unsigned START_MS_LONG    = 120;

  // Start window length in ticks; the reserved code falls back to nominal.
  function automatic int unsigned start_window_ms(input logic [1:0] sel);
    case (sel)
      2'b01:   return START_MS_SHORT;
      2'b10:   return START_MS_LONG;
      default: return START_MS_NOMINAL;
    endcase
  endfunction

  // Cool-down length in ticks: base scaled by a power of two.
  function automatic int unsigned cool_ticks(input logic [1:0] sel, input int unsigned base);
    return base << sel;
  endfunction

  // Detection restart only in the automatic modes with both enables set.
  function automatic logic restart_allowed(input logic [1:0] md, input logic den, input logic cen);
    return md[1] && den && cen;
  endfunction

endpackage

// File: rtl/pss_win_timer.sv
module pss_win_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             tick,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && tick && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // Fires on the tick that consumes the last remaining count.
  assign expire = run && tick && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_req,
  input  logic       inrush_lim,
  input  logic       fault_off,
  input  logic [1:0] mode,
  input  logic       det_en,
  input  logic       cls_en,
  input  logic       start_expire,
  input  logic       cool_expire,
  output pss_state_e state,
  output logic       load_start,
  output logic       load_cool,
  output logic       start_done,
  output logic       start_fault,
  output logic       det_restart
);

  pss_state_e st_q, st_d;
  logic done_d, sfault_d, restart_d;

  always_comb begin
    st_d       = st_q;
    load_start = 1'b0;
    load_cool  = 1'b0;
    done_d     = 1'b0;
    sfault_d   = 1'b0;
    restart_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (pwr_req && mode != MD_OFF) begin
          st_d       = ST_INRUSH;
          load_start = 1'b1;
        end
      end
      ST_INRUSH: begin
        if (start_expire) begin
          if (inrush_lim) begin
            st_d      = ST_COOL;
            load_cool = 1'b1;
            sfault_d  = 1'b1;
          end else begin
            st_d   = ST_POWERED;
            done_d = 1'b1;
          end
        end
      end
      ST_POWERED: begin
        if (fault_off) begin
          st_d      = ST_COOL;
          load_cool = 1'b1;
        end
      end
      ST_COOL: begin
        if (cool_expire) begin
          st_d      = ST_IDLE;
          restart_d = restart_allowed(mode, det_en, cls_en);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      start_done  <= 1'b0;
      start_fault <= 1'b0;
      det_restart <= 1'b0;
    end else begin
      st_q        <= st_d;
      start_done  <= done_d;
      start_fault <= sfault_d;
      det_restart <= restart_d;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/port_start_seq.sv
module port_start_seq
  import pss_pkg::*;
#(
  parameter int unsigned COOL_BASE_TICKS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       pwr_req,
  input  logic       inrush_lim,
  input  logic       ovld_off,
  input  logic       flim_off,
  input  logic [1:0] mode,
  input  logic       det_en,
  input  logic       cls_en,
  input  logic [1:0] start_sel,
  input  logic [1:0] cool_sel,
  output logic       pwr_good,
  output logic       pwr_en,
  output logic       start_done,
  output logic       start_fault,
  output logic       det_restart
);

  localparam int unsigned START_W = $clog2(START_MS_LONG + 1);
  localparam int unsigned COOL_W  = $clog2(COOL_BASE_TICKS * 8 + 1);

  pss_state_e         state;
  logic               load_start, load_cool;
  logic               start_expire, cool_expire;
  logic [START_W-1:0] start_load;
  logic [COOL_W-1:0]  cool_load;

  // Named internal events, visible to the bound checker.
  logic in_inrush, in_cool, in_powered, fault_off;

  assign in_inrush  = (state == ST_INRUSH);
  assign in_cool    = (state == ST_COOL);
  assign in_powered = (state == ST_POWERED);
  assign fault_off  = ovld_off || flim_off;

  assign start_load = START_W'(start_window_ms(start_sel));
  assign cool_load  = COOL_W'(cool_ticks(cool_sel, COOL_BASE_TICKS));

  pss_win_timer #(.CNT_W(START_W)) u_start_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_start),
    .load_val (start_load),
    .run      (in_inrush),
    .tick     (tick_ms),
    .expire   (start_expire)
  );

  pss_win_timer #(.CNT_W(COOL_W)) u_cool_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_cool),
    .load_val (cool_load),
    .run      (in_cool),
    .tick     (tick_ms),
    .expire   (cool_expire)
  );

  pss_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_req      (pwr_req),
    .inrush_lim   (inrush_lim),
    .fault_off    (fault_off),
    .mode         (mode),
    .det_en       (det_en),
    .cls_en       (cls_en),
    .start_expire (start_expire),
    .cool_expire  (cool_expire),
    .state        (state),
    .load_start   (load_start),
    .load_cool    (load_cool),
    .start_done   (start_done),
    .start_fault  (start_fault),
    .det_restart  (det_restart)
  );

  assign pwr_en   = in_inrush || in_powered;
  assign pwr_good = in_powered;

endmodule

// File: rtl/pss_checker.sv
module pss_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_good,
  input logic       pwr_en,
  input logic       start_done,
  input logic       start_fault,
  input logic       det_restart,
  input logic       ovld_off,
  input logic       flim_off,
  input logic [1:0] mode,
  input logic       det_en,
  input logic       cls_en,
  input logic       in_inrush,
  input logic       in_cool,
  input logic       start_expire
);

  // R10
  good_implies_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> pwr_en);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_done, start_fault, det_restart}));

  // R3
  done_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_done |-> pwr_good);

  // R4
  sfault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_fault |-> (!pwr_en && in_cool));

  // R5
  fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && (ovld_off || flim_off)) |=> (!pwr_en && in_cool));

  // R6
  cool_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_cool |-> !pwr_en);

  // R7
  restart_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_restart |-> ($past(mode[1] && det_en && cls_en) && $fell(in_cool)));

  // R9
  window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_inrush && !start_expire) |=> in_inrush);

endmodule

bind port_start_seq pss_checker u_pss_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_good     (pwr_good),
  .pwr_en       (pwr_en),
  .start_done   (start_done),
  .start_fault  (start_fault),
  .det_restart  (det_restart),
  .ovld_off     (ovld_off),
  .flim_off     (flim_off),
  .mode         (mode),
  .det_en       (det_en),
  .cls_en       (cls_en),
  .in_inrush    (in_inrush),
  .in_cool      (in_cool),
  .start_expire (start_expire)
);

// File: tb/test_port_start_seq.sv
module test_port_start_seq;

  localparam int unsigned BASE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b1;
  logic pwr_req = 1'b0, inrush_lim = 1'b0, ovld_off = 1'b0, flim_off = 1'b0;
  logic [1:0] mode = 2'b11, start_sel = 2'b00, cool_sel = 2'b00;
  logic det_en = 1'b1, cls_en = 1'b1;
  logic pwr_good, pwr_en, start_done, start_fault, det_restart;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  port_start_seq #(.COOL_BASE_TICKS(BASE)) i_port_start_seq (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pwr_req(pwr_req),
    .inrush_lim(inrush_lim), .ovld_off(ovld_off), .flim_off(flim_off),
    .mode(mode), .det_en(det_en), .cls_en(cls_en), .start_sel(start_sel),
    .cool_sel(cool_sel), .pwr_good(pwr_good), .pwr_en(pwr_en),
    .start_done(start_done), .start_fault(start_fault), .det_restart(det_restart)
  );

  function automatic int exp_start(input int sel);
    if (sel == 1) return 30;
    if (sel == 2) return 120;
    return 60;
  endfunction

  function automatic int exp_cool(input int sel);
    return BASE * (2 ** sel);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int m, input int s, input int c);
    logic lim;
    int n, z, rs, rs_at, guard;
    lim = 1'(s % 2) ^ 1'(c % 2);
    mode = 2'(m); start_sel = 2'(s); cool_sel = 2'(c);
    det_en = (c != 1); cls_en = (c != 2);
    @(negedge clk);
    if (m == 0) begin
      pwr_req = 1; @(negedge clk); pwr_req = 0;
      repeat (3) @(negedge clk);
      chk("R8 off-mode request ignored", int'(pwr_en), 0);
      return;
    end
    inrush_lim = lim; pwr_req = 1;
    @(negedge clk);
    pwr_req = 0;
    n = 0;
    while (pwr_en && !pwr_good && n < 1000) begin
      n++;
      ovld_off = (n == 2); flim_off = (n == 3); pwr_req = (n == 5);
      @(negedge clk);
    end
    ovld_off = 0; flim_off = 0; pwr_req = 0;
    chk("R2/R9/R8 start window length", n, exp_start(s));
    if (lim) begin
      chk("R4 start_fault strobe", int'(start_fault), 1);
      chk("R4 port off after start fault", int'(pwr_en) + int'(pwr_good), 0);
      chk("R10 single strobe", int'(start_done) + int'(det_restart), 0);
      inrush_lim = 0;
    end else begin
      chk("R3 start_done strobe", int'(start_done), 1);
      chk("R3 good after window", int'(pwr_good), 1);
      @(negedge clk);
      chk("R3 start_done one cycle", int'(start_done), 0);
      pwr_req = 1; @(negedge clk); pwr_req = 0; @(negedge clk);
      chk("R8 request on good port ignored", int'(pwr_good) * 2 + int'(start_done), 2);
      if (c % 2 == 1) ovld_off = 1; else flim_off = 1;
      @(negedge clk);
      ovld_off = 0; flim_off = 0;
      chk("R5 fault turn-off", int'(pwr_en) + int'(pwr_good), 0);
    end
    // first cool-down cycle: hold a request and count unpowered cycles
    pwr_req = 1; z = 0; rs = 0; rs_at = 0;
    while (!pwr_en && z < 100000) begin
      z++;
      if (det_restart) begin rs++; rs_at = z; end
      @(negedge clk);
    end
    pwr_req = 0;
    chk("R6 cool-down length", z, exp_cool(c) + 1);
    chk("R7 detection restart", rs, (m >= 2 && det_en && cls_en) ? 1 : 0);
    if (rs == 1) chk("R7 restart in first idle cycle", rs_at, z);
    // back to idle through a start fault
    inrush_lim = 1; guard = 0;
    while (pwr_en && guard < 1000) begin guard++; @(negedge clk); end
    inrush_lim = 0;
    repeat (exp_cool(c) + 3) @(negedge clk);
    chk("R6 idle after cool-down, unpowered", int'(pwr_en), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pwr_en", int'(pwr_en), 0);
    chk("R1 reset strobes", int'(pwr_good) + int'(start_done) + int'(start_fault) + int'(det_restart), 0);
    rst_n = 1;
    @(negedge clk);
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 4; c++)
          run_case(m, s, c);
    // window advances only on ticks
    begin
      int n;
      mode = 2'b11; start_sel = 2'b10; inrush_lim = 0;
      pwr_req = 1; @(negedge clk); pwr_req = 0;
      tick_ms = 0;
      repeat (300) @(negedge clk);
      chk("R2 no tick keeps window open", int'(pwr_en) * 2 + int'(pwr_good), 2);
      tick_ms = 1; n = 0;
      while (pwr_en && !pwr_good && n < 1000) begin n++; @(negedge clk); end
      chk("R2 window after tick pause", n, 120);
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R1..all: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule